// File: doc/BRIEF.md
# Programming-Guarded Test Access Port

This block is a four-wire serial test access port whose instruction set is cut down to one standard instruction (a one-bit pass-through). The rest of the instruction set drives a nonvolatile configuration store kept outside the block. The store is only ever touched after a 16-bit password has opened a programming mode. A fixed sequence is enforced: open the mode, bulk erase, shift the new pattern in, then commit it with a program command. While the mode is open, the chip's user outputs are held at high impedance.

A security flag, seeded from the store at reset, stops both committing and reading back the pattern. Only a bulk erase clears it. The store sees level strobes, one per TCK cycle, for erase, program, serial load and read capture. It returns its serial read data on `cfg_sdo`, and during a load it takes its serial write data straight from `tdi`.

Top module: `isp_tap_guard`

## Requirements
- R1: The controller walks the standard sixteen-state sequence on rising TCK. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state. A low `rst_n` sampled on a rising TCK edge also forces Test-Logic-Reset.
- R2: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads 4'b0001, so the first bits out are 1,0,0,0. Reset and Test-Logic-Reset select the pass-through code 4'b1111.
- R3: Under the pass-through code, the data path is one bit long and captures 0. The first TDO bit of a data scan is 0, and each later bit repeats the TDI bit one shift earlier.
- R4: Every code except 4'h2, 4'h3, 4'h4, 4'h5 and 4'h6 (for example 4'h0 and 4'h1) behaves exactly like the pass-through code.
- R5: TDO is registered on the falling TCK edge and holds across the rising edge. `tdo_en` is high only in Shift-IR and Shift-DR.
- R6: Under code 4'h2, a 16-bit data path takes the password least significant bit first. Update-DR with the right value opens programming mode, and a wrong value closes it. Test-Logic-Reset also closes it. `user_hiz` is high exactly while the mode is open.
- R7: Under code 4'h3 with the mode open, `cfg_erase` is high in every Run-Test/Idle cycle. Erasing clears the security flag and arms the load step. With the mode closed, it stays low.
- R8: Under code 4'h4 with the mode open, `cfg_shift` is high in every Shift-DR cycle. The following Update-DR marks the pattern loaded only if an erase has happened since the mode opened.
- R9: Under code 4'h5, `cfg_prog` is high in every Run-Test/Idle cycle only when the mode is open, a pattern is loaded and the security flag is clear.
- R10: Under code 4'h6 with the mode open and the security flag clear, `cfg_read` is high in Capture-DR and TDO carries `cfg_sdo` during Shift-DR. Otherwise `cfg_read` stays low and TDO shifts zeros.
- R11: The security flag takes the value of `lock_nv` while `rst_n` is low, and it blocks both program and readback.
- R12: At most one of `cfg_erase`, `cfg_shift`, `cfg_prog` and `cfg_read` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset, synchronous to rising TCK |
| tms | input | 1 | Mode select for the controller |
| tdi | input | 1 | Serial data in; also the store's load data |
| tdo | output | 1 | Serial data out, valid while `tdo_en` is high |
| tdo_en | output | 1 | Output enable for TDO |
| lock_nv | input | 1 | Stored security flag, loaded during reset |
| cfg_sdo | input | 1 | Serial readback from the store |
| user_hiz | output | 1 | Forces the chip's user outputs to high impedance |
| cfg_erase | output | 1 | Bulk-erase strobe, one per TCK cycle |
| cfg_shift | output | 1 | Serial load enable for the store |
| cfg_prog | output | 1 | Commit strobe, one per TCK cycle |
| cfg_read | output | 1 | Readback capture strobe |

## Verification
The bench builds the block with a 16-bit password width and a password value of its own, 16'h3C5A, which differs from the default. This checks that the unlock compare follows the parameter and not a fixed constant. With 16 bits, random wrong passwords and a full scan of the password path fit easily within the run. The bench also restarts with the security flag seeded high, which makes it possible to test that readback stays blocked until an erase.

// File: rtl/isp_guard_pkg.sv
// Shared types and instruction codes for the programming-guarded TAP.
// Assumes a 4-bit instruction register; codes not listed decode to pass-through.
package isp_guard_pkg;

    typedef enum logic [3:0] {
        ST_TLR    = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SELDR  = 4'd2,
        ST_CAPDR  = 4'd3,
        ST_SHDR   = 4'd4,
        ST_EX1DR  = 4'd5,
        ST_PAUDR  = 4'd6,
        ST_EX2DR  = 4'd7,
        ST_UPDDR  = 4'd8,
        ST_SELIR  = 4'd9,
        ST_CAPIR  = 4'd10,
        ST_SHIR   = 4'd11,
        ST_EX1IR  = 4'd12,
        ST_PAUIR  = 4'd13,
        ST_EX2IR  = 4'd14,
        ST_UPDIR  = 4'd15
    } tap_state_e;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_UNLOCK  = 4'h2;
    localparam logic [IR_W-1:0] OP_ERASE   = 4'h3;
    localparam logic [IR_W-1:0] OP_LOAD    = 4'h4;
    localparam logic [IR_W-1:0] OP_PROGRAM = 4'h5;
    localparam logic [IR_W-1:0] OP_VERIFY  = 4'h6;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'h1;

    typedef enum logic [1:0] {
        DR_BYPASS = 2'd0,
        DR_PASSWD = 2'd1,
        DR_CFG    = 2'd2
    } dr_sel_e;

endpackage

// File: rtl/isp_tap_fsm.sv
// Sixteen-state test controller clocked on rising TCK.
// Assumes rst_n is synchronous to TCK; reset lands in Test-Logic-Reset.
module isp_tap_fsm
    import isp_guard_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e state_nx;

    // Next-state decode from the present state and TMS.
    always_comb begin
        unique case (state)
            ST_TLR:   state_nx = tms ? ST_TLR   : ST_IDLE;
            ST_IDLE:  state_nx = tms ? ST_SELDR : ST_IDLE;
            ST_SELDR: state_nx = tms ? ST_SELIR : ST_CAPDR;
            ST_CAPDR: state_nx = tms ? ST_EX1DR : ST_SHDR;
            ST_SHDR:  state_nx = tms ? ST_EX1DR : ST_SHDR;
            ST_EX1DR: state_nx = tms ? ST_UPDDR : ST_PAUDR;
            ST_PAUDR: state_nx = tms ? ST_EX2DR : ST_PAUDR;
            ST_EX2DR: state_nx = tms ? ST_UPDDR : ST_SHDR;
            ST_UPDDR: state_nx = tms ? ST_SELDR : ST_IDLE;
            ST_SELIR: state_nx = tms ? ST_TLR   : ST_CAPIR;
            ST_CAPIR: state_nx = tms ? ST_EX1IR : ST_SHIR;
            ST_SHIR:  state_nx = tms ? ST_EX1IR : ST_SHIR;
            ST_EX1IR: state_nx = tms ? ST_UPDIR : ST_PAUIR;
            ST_PAUIR: state_nx = tms ? ST_EX2IR : ST_PAUIR;
            ST_EX2IR: state_nx = tms ? ST_UPDIR : ST_SHIR;
            ST_UPDIR: state_nx = tms ? ST_SELDR : ST_IDLE;
            default:  state_nx = ST_TLR;
        endcase
    end

    // State register with synchronous reset into Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_TLR;
        else        state <= state_nx;
    end

endmodule

// File: rtl/isp_scan_regs.sv
// Instruction register, pass-through bit and password shifter, plus the
// falling-edge TDO stage. Assumes cfg_out is already gated by the caller.
module isp_scan_regs
    import isp_guard_pkg::*;
#(
    parameter int PW_W = 16
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    input  logic            cfg_out,
    output logic [IR_W-1:0] ir,
    output logic [PW_W-1:0] pw_value,
    output logic            tdo,
    output logic            tdo_en
);

    logic [IR_W-1:0] ir_sr;
    logic [PW_W-1:0] pw_sr;
    logic            byp_q;
    dr_sel_e         dr_sel;
    logic            tdo_nx;

    // Decode which data path sits between TDI and TDO.
    always_comb begin
        unique case (ir)
            OP_UNLOCK:         dr_sel = DR_PASSWD;
            OP_LOAD,
            OP_VERIFY:         dr_sel = DR_CFG;
            default:           dr_sel = DR_BYPASS;
        endcase
    end

    // Instruction shifter: capture the fixed pattern, shift LSB first.
    always_ff @(posedge tck) begin
        if (!rst_n)                 ir_sr <= IR_CAPTURE;
        else if (state == ST_CAPIR) ir_sr <= IR_CAPTURE;
        else if (state == ST_SHIR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Active instruction: pass-through after reset, loaded on Update-IR.
    always_ff @(posedge tck) begin
        if (!rst_n)                 ir <= OP_BYPASS;
        else if (state == ST_TLR)   ir <= OP_BYPASS;
        else if (state == ST_UPDIR) ir <= ir_sr;
    end

    // One-bit pass-through register, captures zero.
    always_ff @(posedge tck) begin
        if (!rst_n)                 byp_q <= 1'b0;
        else if (state == ST_CAPDR) byp_q <= 1'b0;
        else if (state == ST_SHDR)  byp_q <= tdi;
    end

    // Password shifter, only active while its instruction is selected.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            pw_sr <= '0;
        end else if (dr_sel == DR_PASSWD) begin
            if (state == ST_CAPDR)     pw_sr <= '0;
            else if (state == ST_SHDR) pw_sr <= {tdi, pw_sr[PW_W-1:1]};
        end
    end

    assign pw_value = pw_sr;

    // Pick the bit that leaves on TDO in the present shift state.
    always_comb begin
        tdo_nx = 1'b0;
        if (state == ST_SHIR) begin
            tdo_nx = ir_sr[0];
        end else if (state == ST_SHDR) begin
            unique case (dr_sel)
                DR_PASSWD: tdo_nx = pw_sr[0];
                DR_CFG:    tdo_nx = cfg_out;
                default:   tdo_nx = byp_q;
            endcase
        end
    end

    // Falling-edge output stage for TDO and its enable.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= tdo_nx;
            tdo_en <= (state == ST_SHIR) || (state == ST_SHDR);
        end
    end

endmodule

// File: rtl/isp_prog_ctrl.sv
// Programming-mode guard: password unlock, erase/load/program ordering,
// security flag and the strobes toward the configuration store.
// Assumes the store latches strobes on rising TCK.
module isp_prog_ctrl
    import isp_guard_pkg::*;
#(
    parameter int              PW_W     = 16,
    parameter logic [PW_W-1:0] PASSWORD = 16'hB7E1
) (
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic [IR_W-1:0] ir,
    input  logic [PW_W-1:0] pw_value,
    input  logic            lock_nv,
    output logic            mode,
    output logic            lock,
    output logic            rd_allow,
    output logic            cfg_erase,
    output logic            cfg_shift,
    output logic            cfg_prog,
    output logic            cfg_read
);

    logic erased_q;
    logic loaded_q;
    logic pw_hit;

    assign pw_hit = (pw_value == PASSWORD);

    // Strobe qualification: each needs the open mode and its own code.
    always_comb begin
        cfg_erase = mode && (ir == OP_ERASE) && (state == ST_IDLE);
        cfg_shift = mode && (ir == OP_LOAD) && (state == ST_SHDR);
        cfg_prog  = mode && (ir == OP_PROGRAM) && (state == ST_IDLE)
                    && loaded_q && !lock;
        rd_allow  = mode && (ir == OP_VERIFY) && !lock;
        cfg_read  = rd_allow && (state == ST_CAPDR);
    end

    // Mode and sequence flags: unlock, erase arms load, load arms program.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_TLR) begin
            mode     <= 1'b0;
            erased_q <= 1'b0;
            loaded_q <= 1'b0;
        end else begin
            if (state == ST_UPDDR && ir == OP_UNLOCK) begin
                mode <= pw_hit;
                if (!pw_hit) begin
                    erased_q <= 1'b0;
                    loaded_q <= 1'b0;
                end
            end
            if (cfg_erase) begin
                erased_q <= 1'b1;
                loaded_q <= 1'b0;
            end
            if (state == ST_UPDDR && ir == OP_LOAD && mode && erased_q)
                loaded_q <= 1'b1;
        end
    end

    // Security flag: seeded from the store in reset, cleared by erase.
    always_ff @(posedge tck) begin
        if (!rst_n)         lock <= lock_nv;
        else if (cfg_erase) lock <= 1'b0;
    end

endmodule

// File: rtl/isp_tap_guard.sv
// Top level: test access port whose private instructions drive a guarded
// programming interface. Assumes user I/O tristate is applied by the pads.
module isp_tap_guard
    import isp_guard_pkg::*;
#(
    parameter int              PW_W     = 16,
    parameter logic [PW_W-1:0] PASSWORD = 16'hB7E1
) (
    input  logic tck,
    input  logic rst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    input  logic lock_nv,
    input  logic cfg_sdo,
    output logic user_hiz,
    output logic cfg_erase,
    output logic cfg_shift,
    output logic cfg_prog,
    output logic cfg_read
);

    tap_state_e      state_w;
    logic [IR_W-1:0] ir_w;
    logic [PW_W-1:0] pw_w;
    logic            mode_w;
    logic            lock_w;
    logic            rd_allow_w;
    logic            cfg_out_w;

    // Readback reaches TDO only when verify is permitted.
    assign cfg_out_w = rd_allow_w & cfg_sdo;
    assign user_hiz  = mode_w;

    isp_tap_fsm i_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state_w)
    );

    isp_scan_regs #(.PW_W(PW_W)) i_regs (
        .tck      (tck),
        .rst_n    (rst_n),
        .tdi      (tdi),
        .state    (state_w),
        .cfg_out  (cfg_out_w),
        .ir       (ir_w),
        .pw_value (pw_w),
        .tdo      (tdo),
        .tdo_en   (tdo_en)
    );

    isp_prog_ctrl #(.PW_W(PW_W), .PASSWORD(PASSWORD)) i_ctrl (
        .tck       (tck),
        .rst_n     (rst_n),
        .state     (state_w),
        .ir        (ir_w),
        .pw_value  (pw_w),
        .lock_nv   (lock_nv),
        .mode      (mode_w),
        .lock      (lock_w),
        .rd_allow  (rd_allow_w),
        .cfg_erase (cfg_erase),
        .cfg_shift (cfg_shift),
        .cfg_prog  (cfg_prog),
        .cfg_read  (cfg_read)
    );

endmodule

// File: rtl/isp_tap_guard_chk.sv
// Checker for isp_tap_guard, attached by bind. Tracks consecutive TMS-high
// edges with a saturating counter to check the reset-by-TMS rule.
module isp_tap_guard_chk
    import isp_guard_pkg::*;
(
    input logic       tck,
    input logic       rst_n,
    input logic       tms,
    input tap_state_e state,
    input logic       lock,
    input logic       user_hiz,
    input logic       tdo_en,
    input logic       cfg_erase,
    input logic       cfg_shift,
    input logic       cfg_prog,
    input logic       cfg_read
);

    logic [2:0] ones_cnt;

    // Count rising edges in a row that saw TMS high, saturating at 7.
    always_ff @(posedge tck) begin
        if (!rst_n)     ones_cnt <= 3'd0;
        else if (!tms)  ones_cnt <= 3'd0;
        else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_cnt >= 3'd5) |-> (state == ST_TLR)); // R1

    AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en |-> (state == ST_SHIR || state == ST_SHDR)); // R5

    AST_TLR_CLOSES_MODE: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_TLR) |=> !user_hiz); // R6

    AST_ERASE_NEEDS_MODE: assert property (@(posedge tck) disable iff (!rst_n)
        cfg_erase |-> (user_hiz && state == ST_IDLE)); // R7

    AST_ERASE_UNLOCKS: assert property (@(posedge tck) disable iff (!rst_n)
        cfg_erase |=> !lock); // R7

    AST_SHIFT_IN_SHDR: assert property (@(posedge tck) disable iff (!rst_n)
        cfg_shift |-> (user_hiz && state == ST_SHDR)); // R8

    AST_PROG_NEEDS_UNLOCK: assert property (@(posedge tck) disable iff (!rst_n)
        cfg_prog |-> (user_hiz && !lock)); // R9

    AST_READ_GUARDED: assert property (@(posedge tck) disable iff (!rst_n)
        cfg_read |-> (user_hiz && !lock && state == ST_CAPDR)); // R10

    AST_LOCK_HOLDS: assert property (@(posedge tck) disable iff (!rst_n)
        (lock && !cfg_erase) |=> lock); // R11

    AST_ONE_STROBE: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({cfg_erase, cfg_shift, cfg_prog, cfg_read})); // R12

endmodule

bind isp_tap_guard isp_tap_guard_chk i_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .tms       (tms),
    .state     (state_w),
    .lock      (lock_w),
    .user_hiz  (user_hiz),
    .tdo_en    (tdo_en),
    .cfg_erase (cfg_erase),
    .cfg_shift (cfg_shift),
    .cfg_prog  (cfg_prog),
    .cfg_read  (cfg_read)
);

// File: tb/test_isp_tap_guard.sv
// Bench for isp_tap_guard: directed sequences plus seeded random codes,
// passwords and TMS walks, checked against bench-side expectations.
module test_isp_tap_guard;

    localparam logic [15:0] PW = 16'h3C5A;

    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic lock_nv = 1'b0;
    logic cfg_sdo = 1'b0;
    logic tdo, tdo_en, user_hiz, cfg_erase, cfg_shift, cfg_prog, cfg_read;

    int n_tests = 0;
    int n_fail  = 0;
    int cnt_er, cnt_sh, cnt_pg, cnt_rd;
    logic s_tdo, s_en, s_hiz;
    logic [31:0] out_v;
    logic [3:0]  cap_v;
    logic        en_all;

    always #5 tck = ~tck;

    isp_tap_guard #(.PW_W(16), .PASSWORD(PW)) i_isp_tap_guard (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_en(tdo_en), .lock_nv(lock_nv), .cfg_sdo(cfg_sdo),
        .user_hiz(user_hiz), .cfg_erase(cfg_erase), .cfg_shift(cfg_shift),
        .cfg_prog(cfg_prog), .cfg_read(cfg_read)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] byp_exp(input logic [31:0] d, input int n);
        return (d << 1) & ((32'h1 << n) - 32'h1);
    endfunction

    // One TCK cycle: drive after the falling edge, sample before the rise.
    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        #3;
        s_tdo = tdo;
        s_en  = tdo_en;
        s_hiz = user_hiz;
        cnt_er += int'(cfg_erase);
        cnt_sh += int'(cfg_shift);
        cnt_pg += int'(cfg_prog);
        cnt_rd += int'(cfg_read);
    endtask

    task automatic clr();
        cnt_er = 0; cnt_sh = 0; cnt_pg = 0; cnt_rd = 0;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(1'b0, 1'b0);
    endtask

    task automatic tap_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic shift_ir(input logic [3:0] code);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, code[i]);
            cap_v[i] = s_tdo;
        end
        step(1'b1, 1'b0); step(1'b0, 1'b0);
    endtask

    task automatic shift_dr(input logic [31:0] d, input int n);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        out_v  = '0;
        en_all = 1'b1;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, d[i]);
            out_v[i] = s_tdo;
            en_all   = en_all & s_en;
        end
        step(1'b1, 1'b0); step(1'b0, 1'b0);
    endtask

    task automatic unlock(input logic [15:0] p);
        shift_ir(4'h2);
        shift_dr({16'h0, p}, 16);
    endtask

    initial begin
        logic [31:0] d;
        logic [3:0]  code;
        logic [15:0] bad;
        logic        v0, v1;
        void'($urandom(32'd1234));
        clr();
        repeat (3) @(posedge tck);
        #1;
        chk("R1 reset tdo_en", tdo_en, 0);
        chk("R1 reset user_hiz", user_hiz, 0);
        chk("R12 reset strobes", {cfg_erase, cfg_shift, cfg_prog, cfg_read}, 0);
        @(negedge tck); rst_n = 1'b1;
        tap_reset();

        // R2: reset selects pass-through; R3 one-bit delay.
        d = 32'h00B5;
        shift_dr(d, 8);
        chk("R2 reset selects bypass", out_v, byp_exp(d, 8));
        chk("R5 tdo_en in shift", en_all, 1);
        idle(1);
        chk("R5 tdo_en in idle", s_en, 0);
        shift_ir(4'hF);
        chk("R2 IR capture 0001", cap_v, 4'h1);
        d = 32'h00C3;
        shift_dr(d, 8);
        chk("R3 bypass delay", out_v, byp_exp(d, 8));

        // R5: TDO holds across the rising edge, moves on the falling one.
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        v0 = s_tdo;
        @(posedge tck); #1; v1 = tdo;
        chk("R5 tdo stable over rise", v1, v0);
        step(1'b1, 1'b0);
        chk("R5 tdo after fall", s_tdo, 1);
        step(1'b1, 1'b0); step(1'b0, 1'b0);

        // R4: unsupported codes act as pass-through.
        for (int k = 0; k < 8; k++) begin
            if (k == 0) code = 4'h0;
            else if (k == 1) code = 4'h1;
            else begin
                code = 4'($urandom);
                if (code >= 4'h2 && code <= 4'h6) code = code + 4'h5;
            end
            shift_ir(code);
            d = $urandom & 32'hFFF;
            shift_dr(d, 12);
            chk("R4 unknown code bypass", out_v, byp_exp(d, 12));
        end

        // R7: erase without mode does nothing.
        shift_ir(4'h3); clr(); idle(3);
        chk("R7 erase blocked without mode", cnt_er, 0);

        // R6: wrong passwords keep the mode closed.
        for (int k = 0; k < 4; k++) begin
            bad = 16'($urandom);
            if (bad == PW) bad = bad ^ 16'h1;
            unlock(bad); idle(1);
            chk("R6 wrong password", s_hiz, 0);
        end
        unlock(PW); idle(1);
        chk("R6 right password opens", s_hiz, 1);

        // R9: program before erase/load is refused.
        shift_ir(4'h5); clr(); idle(3);
        chk("R9 program before erase", cnt_pg, 0);
        // R8: load before erase shifts but does not arm program.
        shift_ir(4'h4); clr(); shift_dr(32'h5A, 8);
        chk("R8 shift strobe count", cnt_sh, 8);
        chk("R12 no other strobe in load", cnt_er + cnt_pg + cnt_rd, 0);
        shift_ir(4'h5); clr(); idle(3);
        chk("R8 load without erase not armed", cnt_pg, 0);

        // R7/R8/R9: full ordered sequence.
        shift_ir(4'h3); clr(); idle(4);
        chk("R7 erase strobes", cnt_er, 4);
        shift_ir(4'h4); shift_dr(32'hA7, 8);
        shift_ir(4'h5); clr(); idle(3);
        chk("R9 program after erase and load", cnt_pg, 3);

        // R10: verify readback when unlocked.
        cfg_sdo = 1'b1;
        shift_ir(4'h6); clr(); shift_dr(32'h0, 8);
        chk("R10 verify data", out_v, 32'hFF);
        chk("R10 verify capture strobe", cnt_rd, 1);

        // R6: mismatch closes the mode.
        unlock(PW ^ 16'h8000); idle(1);
        chk("R6 mismatch closes mode", s_hiz, 0);

        // R1: random TMS walk then five ones reach Test-Logic-Reset.
        unlock(PW); idle(1);
        for (int k = 0; k < 24; k++) step(1'($urandom), 1'($urandom));
        tap_reset(); idle(1);
        chk("R1 five ones close mode", s_hiz, 0);
        shift_ir(4'hF);
        chk("R1 controller in sync", cap_v, 4'h1);

        // R11: security flag from reset blocks verify until erase.
        @(negedge tck); rst_n = 1'b0; lock_nv = 1'b1;
        repeat (2) @(posedge tck);
        @(negedge tck); rst_n = 1'b1; lock_nv = 1'b0;
        tap_reset();
        unlock(PW);
        shift_ir(4'h6); clr(); shift_dr(32'h0, 8);
        chk("R11 locked verify data", out_v, 0);
        chk("R11 locked verify strobe", cnt_rd, 0);
        shift_ir(4'h3); idle(2);
        shift_ir(4'h6); clr(); shift_dr(32'h0, 8);
        chk("R7 erase clears lock", out_v, 32'hFF);
        chk("R10 verify after erase", cnt_rd, 1);

        // R6: Test-Logic-Reset closes mode.
        tap_reset(); idle(1);
        chk("R6 reset state closes mode", s_hiz, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge tck);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule